// File: doc/BRIEF.md
# CPU and PCI Clock Mode Divider

This block turns a fast internal clock into a CPU clock and a PCI clock whose edges stay locked to each other. The internal clock stands in for the PLL output and runs at twice the target CPU rate. A two-bit mode select picks one of four behaviours: all outputs disabled, 66 MHz operation, a test mode, or 100 MHz operation. In 66 MHz operation the PCI clock is the CPU clock divided by 2. In 100 MHz operation it is the CPU clock divided by 3. In test mode both clocks are derived from a separate test clock, and the reference output carries the test clock unchanged.

The disabled mode does not create tristate nets. It raises three active-low enable flags, one each for the CPU, PCI and reference output groups, and the pad drivers outside this block act on those flags. The free-running PCI output and the gated PCI output leave the block as the same divided clock, and their stop gating is applied elsewhere. The select pins are brought into each clock domain through a short synchronizer. Any change of the select restarts the divider counters, so the CPU and PCI edges fall back into line at once.

Top module: `ckgen_top`

## Requirements
- R1: The select value {selSpeed, selAux} decodes as 00 = disabled, 01 = 66 MHz active, 10 = test, 11 = 100 MHz active. In the disabled mode cpuOeN, pciOeN and refOeN are all 1. In every other mode all three are 0.
- R2: While the block is in reset, and in the disabled mode, cpuClk, pciClk and pciFreeClk are held low.
- R3: In both active modes cpuClk toggles on every pllClk rising edge. It is therefore pllClk divided by 2, with a 50% duty cycle.
- R4: The PCI clock is high for r source cycles and low for r source cycles, where the source is pllClk or testClk. r is 2 in the 66 MHz mode, which gives CPU/2. r is 3 in the 100 MHz and test modes, which gives CPU/3.
- R5: Every rising edge of pciClk occurs in the same source cycle as a rising edge of cpuClk.
- R6: pciFreeClk is identical to pciClk in every mode.
- R7: The select is synchronized through SYNC_STAGES flops in each domain. A select change that is set up before source rising edge 1 restarts the dividers at rising edge SYNC_STAGES+1 (the third edge by default). At that edge cpuClk and pciClk both go high, which is phase 0 of the new mode.
- R8: In test mode cpuClk is testClk divided by 2 and pciClk is testClk divided by 6. Both have a 50% duty cycle.
- R9: refClk follows testClk in test mode and oscClk in every other mode.
- R10: During reset the enable flags are all 1, because the synchronized mode resets to disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pllClk | input | 1 | Internal fast clock at twice the CPU rate |
| testClk | input | 1 | Test clock used in test mode |
| oscClk | input | 1 | Reference oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selSpeed | input | 1 | Mode select, upper bit |
| selAux | input | 1 | Mode select, lower bit |
| cpuClk | output | 1 | CPU clock |
| pciClk | output | 1 | Gated-group PCI clock source |
| pciFreeClk | output | 1 | Free-running PCI clock |
| refClk | output | 1 | Reference clock |
| cpuOeN | output | 1 | Active-low enable, CPU group |
| pciOeN | output | 1 | Active-low enable, PCI group |
| refOeN | output | 1 | Active-low enable, reference group |

## Verification
A divider counter that is off by one phase, or that wraps at the wrong limit, becomes visible at the ports within one PCI period of the restart edge. It shows up either as a PCI rise with no CPU rise beside it or as a high or low run of the wrong length. The bench steps through every ordered pair of distinct modes. After each step it predicts the exact level of both clocks at each sample from the phase index counted from the restart edge. A stale synchronizer stage or a missed restart therefore shows up as a mismatch on the very first sample. A wrong mode decode shows up on the enable flags and the reference source just after the window.

// File: rtl/ckgen_pkg.sv
package ckgen_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_ACT66  = 2'b01,
    MODE_TEST   = 2'b10,
    MODE_ACT100 = 2'b11
  } ckMode_e;

  // strobes from the mode control to one divider
  typedef struct packed {
    logic run;
    logic ratio3;
    logic clear;
  } ckStrb_t;

endpackage

// File: rtl/ckgen_ctrl.sv
module ckgen_ctrl
  import ckgen_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_DOM     = 2
) (
  input  logic    pllClk,
  input  logic    testClk,
  input  logic    rstN,
  input  logic    selSpeed,
  input  logic    selAux,
  output ckStrb_t strb [NUM_DOM],
  output logic    modeOff,
  output logic    modeTest
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_DOM-1:0] domClk;
  ckMode_e            domMode [NUM_DOM];

  always_comb begin
    domClk    = '0;
    domClk[0] = pllClk;
    if (NUM_DOM > 1) domClk[NUM_DOM-1] = testClk;
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    logic [SYNC_STAGES-1:0][1:0] syncQ;
    logic [1:0]                  selPrev;

    always_ff @(posedge domClk[d] or negedge rstN) begin
      if (!rstN) begin
        syncQ   <= '0;
        selPrev <= '0;
      end else begin
        syncQ[0] <= {selSpeed, selAux};
        for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
        selPrev <= syncQ[LAST];
      end
    end

    always_comb begin
      domMode[d]   = ckMode_e'(syncQ[LAST]);
      strb[d].clear = (syncQ[LAST] != selPrev);
      if (d == NUM_DOM - 1 && d != 0) begin
        strb[d].run    = (domMode[d] == MODE_TEST);
        strb[d].ratio3 = 1'b1;
      end else begin
        strb[d].run    = (domMode[d] == MODE_ACT66) || (domMode[d] == MODE_ACT100);
        strb[d].ratio3 = (domMode[d] == MODE_ACT100);
      end
    end
  end

  assign modeOff  = (domMode[0] == MODE_OFF);
  assign modeTest = (domMode[0] == MODE_TEST);

endmodule

// File: rtl/ckgen_div.sv
module ckgen_div
  import ckgen_pkg::*;
#(
  parameter int RATIO_LO = 2,
  parameter int RATIO_HI = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  ckStrb_t strb,
  output logic    cpuQ,
  output logic    pciQ
);

  localparam int CNT_W = $clog2(2 * RATIO_HI);
  localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(2 * RATIO_LO - 1);
  localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(2 * RATIO_HI - 1);
  localparam logic [CNT_W-1:0] HALF_LO = CNT_W'(RATIO_LO);
  localparam logic [CNT_W-1:0] HALF_HI = CNT_W'(RATIO_HI);

  logic [CNT_W-1:0] cnt, cntNext, cntLast, halfLen;
  logic             cpuNext, pciNext;

  always_comb begin
    cntLast = strb.ratio3 ? LAST_HI : LAST_LO;
    halfLen = strb.ratio3 ? HALF_HI : HALF_LO;
    if (!strb.run || strb.clear) cntNext = '0;
    else if (cnt == cntLast)     cntNext = '0;
    else                         cntNext = cnt + 1'b1;
    cpuNext = strb.run && !cntNext[0];
    pciNext = strb.run && (cntNext < halfLen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      cpuQ <= 1'b0;
      pciQ <= 1'b0;
    end else begin
      cnt  <= cntNext;
      cpuQ <= cpuNext;
      pciQ <= pciNext;
    end
  end

  AST_PCI_RISE_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pciQ) |-> $rose(cpuQ)); // R5

  AST_CPU_HALF_RATE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.clear && $past(strb.run) && !$past(strb.clear))
      |=> (cpuQ != $past(cpuQ))); // R3

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> (!cpuQ && !pciQ)); // R2

  AST_RESTART_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clear && strb.run) |=> (cpuQ && pciQ)); // R7

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.clear) |-> (cnt <= cntLast)); // R4

endmodule

// File: rtl/ckgen_top.sv
module ckgen_top
  import ckgen_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RATIO_LO    = 2,
  parameter int RATIO_HI    = 3
) (
  input  logic pllClk,
  input  logic testClk,
  input  logic oscClk,
  input  logic rstN,
  input  logic selSpeed,
  input  logic selAux,
  output logic cpuClk,
  output logic pciClk,
  output logic pciFreeClk,
  output logic refClk,
  output logic cpuOeN,
  output logic pciOeN,
  output logic refOeN
);

  localparam int NUM_DOM = 2;

  ckStrb_t            strb [NUM_DOM];
  logic               modeOff, modeTest;
  logic [NUM_DOM-1:0] domClk, divCpu, divPci;

  assign domClk = {testClk, pllClk};

  ckgen_ctrl #(.SYNC_STAGES(SYNC_STAGES), .NUM_DOM(NUM_DOM)) i_ctrl (
    .pllClk   (pllClk),
    .testClk  (testClk),
    .rstN     (rstN),
    .selSpeed (selSpeed),
    .selAux   (selAux),
    .strb     (strb),
    .modeOff  (modeOff),
    .modeTest (modeTest)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_div
    ckgen_div #(.RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI)) i_div (
      .clk  (domClk[d]),
      .rstN (rstN),
      .strb (strb[d]),
      .cpuQ (divCpu[d]),
      .pciQ (divPci[d])
    );
  end

  assign cpuClk     = modeTest ? divCpu[1] : divCpu[0];
  assign pciClk     = modeTest ? divPci[1] : divPci[0];
  assign pciFreeClk = pciClk;
  assign refClk     = modeTest ? testClk : oscClk;
  assign cpuOeN     = modeOff;
  assign pciOeN     = modeOff;
  assign refOeN     = modeOff;

endmodule

// File: tb/test_ckgen_top.sv
module test_ckgen_top;

  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 1;
  localparam int WIN  = 48;

  logic pllClk = 0, testClk = 0, oscClk = 0, rstN = 0;
  logic selSpeed = 0, selAux = 0;
  logic cpuClk, pciClk, pciFreeClk, refClk, cpuOeN, pciOeN, refOeN;
  int   checks = 0, errors = 0;
  logic [1:0] cur = 2'b00;

  always #5  pllClk  = ~pllClk;
  always #7  testClk = ~testClk;
  always #35 oscClk  = ~oscClk;

  ckgen_top #(.SYNC_STAGES(SYNC)) i_ckgen_top (
    .pllClk, .testClk, .oscClk, .rstN, .selSpeed, .selAux,
    .cpuClk, .pciClk, .pciFreeClk, .refClk, .cpuOeN, .pciOeN, .refOeN
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic domEdge(input bit isTest);
    if (isTest) @(negedge testClk); else @(negedge pllClk);
  endtask

  task automatic runMode(input logic [1:0] m);
    bit isT = (m == 2'b10);
    bit act = (m != 2'b00);
    int r   = (m == 2'b01) ? 2 : 3;
    int cpuBad = 0, pciBad = 0, freeBad = 0, alignBad = 0;
    int cpuFirst = 0, pciFirst = 0;
    logic pCpu = 0, pPci = 0;
    domEdge(isT);
    #1 {selSpeed, selAux} = m;
    cur = m;
    repeat (LAT) domEdge(isT);
    for (int k = 0; k < WIN; k++) begin
      logic eCpu, ePci;
      if (k > 0) domEdge(isT);
      eCpu = act && (k % 2 == 0);
      ePci = act && (k % (2 * r) < r);
      if (k == 0) begin cpuFirst = cpuClk; pciFirst = pciClk; end
      if (cpuClk !== eCpu) cpuBad++;
      if (pciClk !== ePci) pciBad++;
      if (pciFreeClk !== pciClk) freeBad++;
      if (k > 0 && pciClk && !pPci && !(cpuClk && !pCpu)) alignBad++;
      pCpu = cpuClk; pPci = pciClk;
    end
    if (!act) begin
      chk(cpuBad == 0 && pciBad == 0, "R2", cpuBad + pciBad, 0);
    end else begin
      chk(cpuBad == 0, isT ? "R8 cpu" : "R3", cpuBad, 0);
      chk(pciBad == 0, isT ? "R8 pci" : "R4", pciBad, 0);
      chk(alignBad == 0, "R5", alignBad, 0);
      chk(cpuFirst == 1 && pciFirst == 1, "R7", cpuFirst * 2 + pciFirst, 3);
    end
    chk(freeBad == 0, "R6", freeBad, 0);
    chk({cpuOeN, pciOeN, refOeN} == (act ? 3'b000 : 3'b111), "R1",
        {cpuOeN, pciOeN, refOeN}, act ? 0 : 7);
    if (act) begin
      int hiV, loV;
      if (isT) begin
        @(posedge testClk); #1 hiV = refClk;
        @(negedge testClk); #1 loV = refClk;
      end else begin
        @(posedge oscClk); #1 hiV = refClk;
        @(negedge oscClk); #1 loV = refClk;
      end
      chk(hiV == 1 && loV == 0, "R9", hiV * 2 + loV, 2);
    end
  endtask

  initial begin
    #20;
    chk({cpuClk, pciClk, pciFreeClk} == 3'b000, "R2 reset", {cpuClk, pciClk, pciFreeClk}, 0);
    chk({cpuOeN, pciOeN, refOeN} == 3'b111, "R10", {cpuOeN, pciOeN, refOeN}, 7);
    #3 rstN = 1;
    repeat (4) @(negedge pllClk);
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        if (a != b) begin
          if (cur != 2'(a)) runMode(2'(a));
          runMode(2'(b));
        end
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule